// File: doc/BRIEF.md
# RTC Periodic and Alarm Interrupt Controller

This block turns timekeeping events from a real-time clock into one level interrupt request. The clock's counters deliver one-cycle tick strobes when the second, minute, hour and day roll over. An external comparator delivers a strobe when the time matches the programmed alarm. A byte-wide control register chooses which tick drives the periodic interrupt, enables the periodic and alarm sources independently, and can mask periodic events while the device is in a sleep state.

A periodic event that arrives while it is masked by sleep is not lost. It is held in a pending flag and delivered on its own once the sleep input drops. That pending event is discarded if software turns off the periodic source before the device wakes. The interrupt output is a sticky level. It stays high until software pulses the clear strobe, and a new event in the same cycle as a clear keeps it high.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and the control register reads 0x00.
- R2: Writing the control register stores bit 4 as the sleep mask, bit 3 as the alarm enable, bit 2 as the periodic enable and bits 1:0 as the period selector. Bits 7:5 always read as 0.
- R3: When the periodic enable is set, the period selector picks the tick line: 00 picks tick_i[0] (second), 01 picks tick_i[1] (minute), 10 picks tick_i[2] (hour) and 11 picks tick_i[3] (day). A pulse on the selected line sets irq_o in the next cycle. Pulses on the other lines are ignored.
- R4: While the periodic enable is 0, no tick pulse raises irq_o.
- R5: A pulse on alarm_hit_i with the alarm enable set raises irq_o in the next cycle. With the alarm enable at 0, the pulse is ignored.
- R6: With the sleep mask at 1 and sleep_i at 1, a selected periodic tick does not raise irq_o.
- R7: A periodic event masked by sleep is held pending. irq_o rises in the cycle after sleep_i returns to 0.
- R8: With the sleep mask at 0, a selected periodic tick raises irq_o even while sleep_i is 1.
- R9: The alarm is never masked by sleep. It raises irq_o while sleep_i is 1 and the sleep mask is 1.
- R10: irq_o stays high until irq_clr_i is pulsed and falls in the next cycle. If a clear and a new event occur in the same cycle, irq_o stays high.
- R11: If the periodic enable is cleared while an event is pending from sleep, the pending event is dropped and no interrupt follows the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read value |
| tick_i | input | 4 | Rollover strobes: [0] second, [1] minute, [2] hour, [3] day |
| alarm_hit_i | input | 1 | One-cycle alarm match strobe |
| sleep_i | input | 1 | Device sleep state |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: four tick lines and an 8-bit control register. With these values every selector code and the three reserved read-back bits can be reached. A behavioural model steps alongside the design and is compared on every cycle. The stimulus covers each selector against each tick line and a sleep entry with a held event and a delayed wake. It also covers the pending event being dropped by a disable during sleep, and a clear that collides with a fresh event.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  typedef enum logic [1:0] {
    PER_SEC  = 2'b00,
    PER_MIN  = 2'b01,
    PER_HOUR = 2'b10,
    PER_DAY  = 2'b11
  } period_e;

  // packed MSB first: bit4 mask, bit3 alarm, bit2 periodic, bits1:0 period
  typedef struct packed {
    logic    sleep_mask;
    logic    alarm_en;
    logic    per_en;
    period_e period;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtc_irq_cfg_reg.sv
module rtc_irq_cfg_reg
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned RSV_W = DATA_W - CTRL_W;

  ctrl_t cfg_q;
  logic  unused_rsv;

  assign unused_rsv = ^wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{RSV_W{1'b0}}, cfg_q};

  // R2: a write lands in the register one cycle later
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[CTRL_W-1:0] == $past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/rtc_irq_period_sel.sv
module rtc_irq_period_sel #(
  parameter int unsigned NUM_TICKS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_TICKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 per_en_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_TICKS-1:0] tick_i,
  output logic                 evt_o
);
  logic [NUM_TICKS-1:0] hit;

  for (genvar g = 0; g < NUM_TICKS; g++) begin : g_tick
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign evt_o = per_en_i && (|hit);

  // R4: disabled periodic source never produces an event
  a_r4_no_periodic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_en_i |-> !evt_o);
  // R3: only one source can be picked at a time
  a_r3_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/rtc_irq_sleep_hold.sv
module rtc_irq_sleep_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic per_en_i,
  input  logic mask_en_i,
  input  logic sleep_i,
  input  logic evt_i,
  output logic fire_o,
  output logic pend_o
);
  logic masked;
  logic pend_q;
  logic deliver;

  assign masked  = mask_en_i && sleep_i;
  assign deliver = pend_q && per_en_i && !masked;
  assign fire_o  = (evt_i && !masked) || deliver;
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (!per_en_i)          pend_q <= 1'b0;
    else if (evt_i && masked)    pend_q <= 1'b1;
    else if (deliver)            pend_q <= 1'b0;
  end

  // R6: masked event is recorded
  a_r6_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_en_i && masked && evt_i) |=> pend_q);
  // R6: nothing periodic leaves while masked
  a_r6_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked |-> !fire_o);
  // R11: disable drops the pending event
  a_r11_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_en_i |=> !pend_q);
endmodule

// File: rtl/rtc_irq_latch.sv
module rtc_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (set_i)  irq_q <= 1'b1;  // event wins over clear
    else if (clr_i)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R10: sticky until cleared
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_q);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_q);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned NUM_TICKS = 4,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_we_i,
  input  logic [DATA_W-1:0]    ctrl_wdata_i,
  output logic [DATA_W-1:0]    ctrl_rdata_o,
  input  logic [NUM_TICKS-1:0] tick_i,
  input  logic                 alarm_hit_i,
  input  logic                 sleep_i,
  input  logic                 irq_clr_i,
  output logic                 irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_TICKS);

  ctrl_t cfg;
  logic  per_evt;
  logic  per_fire;
  logic  pend;
  logic  alarm_fire;
  logic  irq_set;

  rtc_irq_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we_i),
    .wdata_i(ctrl_wdata_i),
    .cfg_o  (cfg),
    .rdata_o(ctrl_rdata_o)
  );

  rtc_irq_period_sel #(.NUM_TICKS(NUM_TICKS)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .per_en_i(cfg.per_en),
    .sel_i   (SEL_W'(cfg.period)),
    .tick_i  (tick_i),
    .evt_o   (per_evt)
  );

  rtc_irq_sleep_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_en_i (cfg.per_en),
    .mask_en_i(cfg.sleep_mask),
    .sleep_i  (sleep_i),
    .evt_i    (per_evt),
    .fire_o   (per_fire),
    .pend_o   (pend)
  );

  // alarm bypasses the sleep mask
  assign alarm_fire = alarm_hit_i && cfg.alarm_en;
  assign irq_set    = per_fire || alarm_fire;

  rtc_irq_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  // R5, R9: enabled alarm always reaches the output
  a_r5_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_hit_i && cfg.alarm_en) |=> irq_o);
  // R7: pending event leaves once sleep drops
  a_r7_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !sleep_i && cfg.per_en) |=> irq_o);
  // R8: unmasked periodic event delivered regardless of sleep
  a_r8_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_evt && !cfg.sleep_mask) |=> irq_o);
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic [3:0] tick = 4'h0;
  logic       alarm = 1'b0;
  logic       sleep = 1'b0;
  logic       clr = 1'b0;
  logic       irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";
  bit    done = 1'b0;

  // reference state
  int m_mask, m_alarm, m_per, m_sel, m_pend, m_irq;

  always #4 clk = ~clk;

  rtc_irq_ctrl u_rtc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .ctrl_rdata_o(rd), .tick_i(tick), .alarm_hit_i(alarm), .sleep_i(sleep),
    .irq_clr_i(clr), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_alarm = 0; m_per = 0; m_sel = 0; m_pend = 0; m_irq = 0;
    end else begin
      int event_now, asleep, hit, nxt_pend;
      asleep    = (m_mask != 0) && sleep;
      hit       = (m_per != 0) && tick[m_sel];
      event_now = 0;
      nxt_pend  = m_pend;
      case ({m_per != 0, asleep != 0})
        2'b10: begin
          if (hit) event_now = 1;
          if (m_pend != 0) begin event_now = 1; nxt_pend = 0; end
        end
        2'b11: if (hit) nxt_pend = 1;
        default: nxt_pend = 0;
      endcase
      if (alarm && m_alarm != 0) event_now = 1;
      if (event_now != 0) m_irq = 1;
      else if (clr)       m_irq = 0;
      m_pend = nxt_pend;
      if (we) begin
        m_mask = wd[4]; m_alarm = wd[3]; m_per = wd[2]; m_sel = wd[1:0];
      end
    end
  end

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = {3'b000, m_mask[0], m_alarm[0], m_per[0], m_sel[1:0]};
    n_cmp++;
    if (irq !== m_irq[0]) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b at %0t", req, irq, m_irq[0], $time);
    end
    n_cmp++;
    if (rd !== exp_rd) begin
      n_bad++;
      $display("FAIL %s ctrl_rdata_o actual=%h expected=%h at %0t", req, rd, exp_rd, $time);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic [3:0] t,
                      input logic a, input logic s, input logic c);
    @(negedge clk);
    compare();
    we = w; wd = d; tick = t; alarm = a; sleep = s; clr = c;
  endtask

  task automatic idle(input int n, input logic s);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 4'h0, 1'b0, s, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d, input logic s);
    step(1'b1, d, 4'h0, 1'b0, s, 1'b0);
  endtask

  task automatic clear_irq();
    step(1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    rst_n = 1'b1;
    idle(3, 1'b0);

    req = "R2";
    wr(8'hFF, 1'b0); idle(2, 1'b0);
    wr(8'hE0, 1'b0); idle(2, 1'b0);
    wr(8'h15, 1'b0); idle(1, 1'b0);
    wr(8'h00, 1'b0); clear_irq(); idle(1, 1'b0);

    req = "R3";
    for (int s = 0; s < 4; s++) begin
      wr(8'h04 | 8'(s), 1'b0);
      for (int t = 0; t < 4; t++) begin
        step(1'b0, 8'h00, 4'(1 << t), 1'b0, 1'b0, 1'b0);
        idle(2, 1'b0);
        clear_irq(); idle(1, 1'b0);
      end
    end

    req = "R4";
    wr(8'h03, 1'b0);
    for (int t = 0; t < 4; t++) step(1'b0, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0);
    idle(2, 1'b0);

    req = "R5";
    wr(8'h00, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0); idle(2, 1'b0);
    wr(8'h08, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0); idle(2, 1'b0);
    clear_irq(); idle(1, 1'b0);

    req = "R6";
    wr(8'h15, 1'b0);
    idle(1, 1'b1);
    step(1'b0, 8'h00, 4'h2, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 4'h2, 1'b0, 1'b1, 1'b0);
    idle(4, 1'b1);
    req = "R7";
    idle(3, 1'b0);
    clear_irq(); idle(2, 1'b0);

    req = "R8";
    wr(8'h06, 1'b1);
    step(1'b0, 8'h00, 4'h4, 1'b0, 1'b1, 1'b0);
    idle(2, 1'b1);
    clear_irq(); idle(1, 1'b0);

    req = "R9";
    wr(8'h18, 1'b1);
    step(1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 1'b0);
    idle(2, 1'b1);
    clear_irq(); idle(1, 1'b0);

    req = "R10";
    wr(8'h0C, 1'b0);
    step(1'b0, 8'h00, 4'h1, 1'b0, 1'b0, 1'b0);
    idle(5, 1'b0);
    step(1'b0, 8'h00, 4'h1, 1'b0, 1'b0, 1'b1);
    idle(2, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b1);
    idle(2, 1'b0);
    clear_irq(); idle(2, 1'b0);

    req = "R11";
    wr(8'h17, 1'b1);
    step(1'b0, 8'h00, 4'h8, 1'b0, 1'b1, 1'b0);
    idle(2, 1'b1);
    wr(8'h13, 1'b1);
    idle(2, 1'b1);
    wr(8'h17, 1'b1);
    idle(2, 1'b1);
    idle(4, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired in %s", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule